// File: doc/BRIEF.md
# Trigger-Latency Pipeline Readout Buffer

This block sits between a detector front-end and its readout link. On every bunch-crossing clock it records one data word together with the crossing identifier supplied alongside it, and keeps both in a circular pipeline for a fixed number of crossings. That number equals the first-level trigger latency. When an accept pulse arrives, the word captured exactly that many crossings earlier is taken from the pipeline. It is tagged with a running event number and placed in a small readout FIFO. Words that no accept claims are overwritten when the pipeline wraps.

The FIFO drains over a valid/ready link. A fragment stays at the FIFO head and does not change until the receiver takes it. A busy flag tells the trigger system that the FIFO is nearly full, so that it can throttle further accepts. If an accept still arrives while every FIFO slot is in use, that accept is dropped and a sticky overflow flag records the loss.

Top module: `l1_pipe_readout`

## Requirements
- R1: An accept sampled on crossing c produces a fragment whose data is the sample presented on crossing c−LATENCY, where crossing 0 is the first clock edge after reset is released.
- R2: The fragment's crossing identifier is the identifier presented on that same earlier crossing, not the one present when the accept arrives.
- R3: The event number starts at 0 after reset and increases by one on every accept, whether or not that accept is stored. Each stored fragment carries the value the counter held when its accept arrived.
- R4: Only accepted crossings produce fragments. The valid output is high exactly while at least one fragment is stored.
- R5: Fragments leave in accept order, one on each clock edge at which valid and ready are both high.
- R6: While valid is high and ready is low, the valid output and all fragment fields hold their values.
- R7: An accept that arrives while all FIFO_DEPTH slots are occupied is discarded. The FIFO contents are left intact. The overflow output then rises and stays high until reset.
- R8: Busy is high exactly when the number of free FIFO slots is below BUSY_THR.
- R9: While reset is held, valid, busy and overflow are low. Reset also empties the FIFO and clears the event counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | DATA_W | Front-end sample for this crossing |
| smp_bx | input | 12 | Crossing identifier for this crossing |
| l1_accept | input | 1 | First-level accept pulse for the crossing LATENCY ago |
| frag_ready | input | 1 | Downstream receiver can take a fragment |
| frag_valid | output | 1 | A fragment is presented |
| frag_data | output | DATA_W | Fragment sample data |
| frag_bx | output | 12 | Fragment crossing identifier |
| frag_evt | output | 24 | Fragment event number |
| busy | output | 1 | Free slots below threshold |
| overflow | output | 1 | Sticky: an accept was dropped |

## Verification
The accept patterns include idle stretches, a single accept, spaced pairs, four accepts back to back with the link ready, and a burst of six accepts into a stalled link. Every sample and identifier changes from crossing to crossing, so a latency that is off by one crossing shows up as a wrong data or identifier value. The stalled burst fills the FIFO and separates dropped accepts from stored ones: event numbers keep counting through the gap, and overflow and busy must rise at the exact fill levels. Alternating ready patterns test order and stall holding. A mid-run reset confirms that the counter and the flags restart.

// File: rtl/l1rb_pkg.sv
package l1rb_pkg;
  localparam int BX_W  = 12;
  localparam int EVT_W = 24;

  // Slot that was written 'lat' crossings before slot 'wp'
  function automatic int unsigned lag_addr(input int unsigned wp,
                                           input int unsigned lat,
                                           input int unsigned depth);
    return (wp + depth - (lat % depth)) % depth;
  endfunction

  function automatic int unsigned free_slots(input int unsigned used,
                                             input int unsigned depth);
    return depth - used;
  endfunction
endpackage

// File: rtl/lat_pipe.sv
module lat_pipe
  import l1rb_pkg::*;
#(
  parameter int W     = 28,
  parameter int DEPTH = 16,
  parameter int LAT   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign rd_ptr  = AW'(lag_addr(32'(wr_ptr), LAT, DEPTH));
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      mem[wr_ptr] <= wr_data;
      wr_ptr      <= (32'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
    end
  end

  assert_ptr_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (32'(wr_ptr) == (32'($past(wr_ptr)) + 1) % DEPTH));

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> mem[$past(wr_ptr)] == $past(wr_data));
endmodule

// File: rtl/frag_fifo.sv
module frag_fifo #(
  parameter int W     = 52,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (32'(count) == DEPTH);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp      <= (32'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
      end
      if (do_pop) rp <= (32'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

  assert_full_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> 32'(count) == DEPTH);

  assert_head_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(dout));
endmodule

// File: rtl/l1_pipe_readout.sv
module l1_pipe_readout
  import l1rb_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LATENCY    = 8,
  parameter int PIPE_DEPTH = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int BUSY_THR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [BX_W-1:0]   smp_bx,
  input  logic              l1_accept,
  input  logic              frag_ready,
  output logic              frag_valid,
  output logic [DATA_W-1:0] frag_data,
  output logic [BX_W-1:0]   frag_bx,
  output logic [EVT_W-1:0]  frag_evt,
  output logic              busy,
  output logic              overflow
);
  localparam int PW = DATA_W + BX_W;
  localparam int FW = EVT_W + PW;
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [PW-1:0]    pipe_out;
  logic [FW-1:0]    fifo_out;
  logic [CW-1:0]    fifo_cnt;
  logic [EVT_W-1:0] evt_cnt;
  logic             fifo_full;
  logic             drop_evt;   // accept lost to a full FIFO
  logic             pop_evt;    // fragment handed downstream

  lat_pipe #(.W(PW), .DEPTH(PIPE_DEPTH), .LAT(LATENCY)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data ({smp_bx, smp_data}),
    .rd_data (pipe_out)
  );

  frag_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (l1_accept),
    .din   ({evt_cnt, pipe_out}),
    .pop   (pop_evt),
    .dout  (fifo_out),
    .count (fifo_cnt)
  );

  assign fifo_full  = (32'(fifo_cnt) == FIFO_DEPTH);
  assign drop_evt   = l1_accept && fifo_full;
  assign frag_valid = (fifo_cnt != '0);
  assign pop_evt    = frag_valid && frag_ready;
  assign {frag_evt, frag_bx, frag_data} = fifo_out;
  assign busy       = free_slots(32'(fifo_cnt), FIFO_DEPTH) < BUSY_THR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_cnt  <= '0;
      overflow <= 1'b0;
    end else begin
      if (l1_accept) evt_cnt <= evt_cnt + 1'b1;
      if (drop_evt) overflow <= 1'b1;
    end
  end

  assert_evt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    l1_accept |=> evt_cnt == $past(evt_cnt) + 1'b1);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_valid_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && !frag_ready) |=> frag_valid);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> (!frag_valid && !overflow));
endmodule

// File: tb/tb_l1_pipe_readout.sv
module tb_l1_pipe_readout;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int LAT  = 8;
  localparam int FD   = 4;
  localparam int THR  = 2;
  localparam int NSEG = 10;
  // each segment: {accept pattern[7:0], ready pattern[7:0]}, bit i = cycle i
  localparam logic [15:0] SEGS [NSEG] = '{
    16'h00FF, 16'h01FF, 16'h05FF, 16'h0FFF, 16'h00FF,
    16'h3F00, 16'h00AA, 16'h1155, 16'h00FF, 16'h00FF};

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] smp_data = '0;
  logic [11:0] smp_bx = '0;
  logic l1_accept = 0, frag_ready = 0;
  logic frag_valid, busy, overflow;
  logic [DW-1:0] frag_data;
  logic [11:0] frag_bx;
  logic [23:0] frag_evt;

  l1_pipe_readout #(.DATA_W(DW), .LATENCY(LAT), .PIPE_DEPTH(16),
                    .FIFO_DEPTH(FD), .BUSY_THR(THR)) dut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_bx(smp_bx),
    .l1_accept(l1_accept), .frag_ready(frag_ready), .frag_valid(frag_valid),
    .frag_data(frag_data), .frag_bx(frag_bx), .frag_evt(frag_evt),
    .busy(busy), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [DW-1:0] h_d [256];
  logic [11:0]   h_b [256];
  logic [DW-1:0] q_d [64];
  logic [11:0]   q_b [64];
  logic [23:0]   q_e [64];
  int wi = 0, ri = 0, mcnt = 0;
  logic [23:0] macc = '0;
  bit movf = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one crossing, check outputs against the model, advance
  task automatic step(input logic a, input logic r);
    bit pop, push;
    smp_data = 16'(cyc * 41 + 7) ^ 16'h5A00;
    smp_bx   = 12'(cyc * 7 + 100);
    l1_accept = a;
    frag_ready = r;
    h_d[cyc & 255] = smp_data;
    h_b[cyc & 255] = smp_bx;
    #1;
    chk(frag_valid == (mcnt != 0), "R4 valid", 32'(frag_valid), 32'(mcnt != 0));
    chk(busy == ((FD - mcnt) < THR), "R8 busy", 32'(busy), 32'((FD - mcnt) < THR));
    chk(overflow == movf, "R7 overflow", 32'(overflow), 32'(movf));
    pop = (mcnt != 0) && r;
    if (pop && frag_valid) begin
      // R5: head must be the oldest stored accept
      chk(frag_data == q_d[ri & 63], "R1 data", 32'(frag_data), 32'(q_d[ri & 63]));
      chk(frag_bx == q_b[ri & 63], "R2 bx", 32'(frag_bx), 32'(q_b[ri & 63]));
      chk(frag_evt == q_e[ri & 63], "R3 evt", 32'(frag_evt), 32'(q_e[ri & 63]));
      ri++;
    end
    push = a && (mcnt < FD);
    if (a && mcnt == FD) movf = 1;
    if (push) begin
      q_d[wi & 63] = h_d[(cyc - LAT) & 255];
      q_b[wi & 63] = h_b[(cyc - LAT) & 255];
      q_e[wi & 63] = macc;
      wi++;
    end
    if (a) macc++;
    mcnt = mcnt + int'(push) - int'(pop);
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; l1_accept = 0; frag_ready = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(!frag_valid, "R9 valid", 32'(frag_valid), 0);
    chk(!busy, "R9 busy", 32'(busy), 0);
    chk(!overflow, "R9 overflow", 32'(overflow), 0);
    @(negedge clk);
    rst_n = 1;
    cyc = 0; wi = 0; ri = 0; mcnt = 0; macc = '0; movf = 0;
  endtask

  initial begin
    logic [DW-1:0] hd;
    logic [23:0] he;
    do_reset();
    // table walk
    for (int s = 0; s < NSEG; s++)
      for (int i = 0; i < 8; i++)
        step(SEGS[s][8+i], SEGS[s][i]);
    // R6: stall with stored fragments, head must hold
    step(1, 0); step(1, 0); step(0, 0);
    hd = frag_data; he = frag_evt;
    step(0, 0); step(0, 0);
    chk(frag_valid, "R6 valid held", 32'(frag_valid), 1);
    chk(frag_data == hd, "R6 data held", 32'(frag_data), 32'(hd));
    chk(frag_evt == he, "R6 evt held", 32'(frag_evt), 32'(he));
    repeat (4) step(0, 1);
    // R9: reset mid-run clears flags and counter, R3 restarts at 0
    do_reset();
    repeat (LAT) step(0, 1);
    step(1, 1);
    step(0, 0);
    chk(frag_evt == 24'd0, "R3 evt after reset", 32'(frag_evt), 0);
    repeat (3) step(0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule